// File: doc/BRIEF.md
# Electroluminescent Segment Driver Control Core

This block holds the logic side of a chainable segment driver for an electroluminescent panel. A host sends segment data one bit at a time on a serial data pin, with a slow serial clock. On each rising edge of the serial clock the data moves one place along a 16-stage shift register. The last stage leaves the block on a serial output, which is updated on the falling edge of the serial clock. That output can feed the data pin of a second unit, so several units form one long chain.

An active-low load input copies the shift register into a 16-bit output latch. The latch follows the shift register while load is low and keeps its value while load is high. An active-low polarity input sets the output mode. In pass mode the segment outputs equal the latch and the backplane output is low. In invert mode every segment output is the complement of its latch bit and the backplane output is high. Toggling polarity therefore gives the panel an AC drive.

The serial clock is treated as a slow strobe. It is synchronized to the system clock and its edges are detected there. The latch is built as a clocked register, not a level-sensitive latch.

Top module: `elseg_drv`

## Requirements
- R1: While the synchronous active-low reset is asserted, the shift register, the latch and the serial output register are cleared. After reset, with polarity high, every segment output, the backplane output and the serial output read 0.
- R2: Each rising edge of the serial clock moves the shift register one place. Stage 0 takes the serial data bit, and stage k takes the old stage k-1. Segment output bit 0 comes from stage 0 and bit 15 comes from stage 15. Between serial clock edges the shift register does not change.
- R3: The serial output carries shift stage 15. It changes only after a falling edge of the serial clock, so a rising edge leaves it unchanged.
- R4: While load is low, the latch follows the shift register, one system clock behind.
- R5: While load is high, the latch holds. Shifting does not change the segment outputs.
- R6: With polarity high (pass mode), segment output bit k equals latch bit k and the backplane output is 0.
- R7: With polarity low (invert mode), segment output bit k equals the complement of latch bit k and the backplane output is 1.
- R8: When the serial output of one unit drives the data input of a second unit, the two act as one 32-stage chain. After 32 rising edges, the first bit sent sits in stage 15 of the downstream unit.
- R9: A change of polarity does not alter the latch. Returning to pass mode restores the earlier segment outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sclk_i | input | 1 | Serial shift clock, sampled as a strobe |
| sdata_i | input | 1 | Serial data input |
| load_n_i | input | 1 | Latch load, active low (latch follows while low) |
| pol_n_i | input | 1 | Polarity: 1 passes, 0 inverts |
| sdata_o | output | 1 | Serial cascade output, last shift stage |
| seg_o | output | 16 | Segment outputs |
| bp_o | output | 1 | Backplane output |

## Verification
The assertions assume the following about the inputs:
- Load and polarity are synchronous to the system clock.
- Each level of the serial clock lasts longer than the synchronizer depth plus one cycle, so a rising strobe and a falling strobe never meet.
- Serial data is stable for the synchronizer depth around each rising serial clock edge.

The stimulus meets these assumptions:
- Every input is driven on the falling system clock edge.
- Each serial clock level is held for six system cycles.
- Data is set six cycles before the rising edge and held until the next bit.

Two instances are chained so that the downstream unit sees the real retimed cascade output.

// File: rtl/elseg_pkg.sv
package elseg_pkg;
    localparam int unsigned SEG_CHANNELS = 16;
    localparam int unsigned SYNC_DEPTH   = 2;

    typedef enum logic {
        POL_INVERT = 1'b0,
        POL_PASS   = 1'b1
    } pol_mode_e;
endpackage

// File: rtl/elseg_strobe.sv
module elseg_strobe #(
    parameter int unsigned SYNC = elseg_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic sdata_i,
    output logic rise_o,
    output logic fall_o,
    output logic data_o
);
    typedef struct packed {
        logic [SYNC-1:0] clk_sh;
        logic [SYNC-1:0] dat_sh;
        logic            clk_prev;
    } strobe_t;

    strobe_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.clk_sh   = {st_q.clk_sh[SYNC-2:0], sclk_i};
        st_d.dat_sh   = {st_q.dat_sh[SYNC-2:0], sdata_i};
        st_d.clk_prev = st_q.clk_sh[SYNC-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.clk_sh[SYNC-1] & ~st_q.clk_prev;
    assign fall_o = ~st_q.clk_sh[SYNC-1] & st_q.clk_prev;
    assign data_o = st_q.dat_sh[SYNC-1];
endmodule

// File: rtl/elseg_shift.sv
module elseg_shift #(
    parameter int unsigned N = elseg_pkg::SEG_CHANNELS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rise_i,
    input  logic         fall_i,
    input  logic         din_i,
    output logic [N-1:0] stages_o,
    output logic         dout_o
);
    localparam int unsigned LAST = N - 1;

    typedef struct packed {
        logic [N-1:0] stage;
        logic         dout;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (rise_i) sh_d.stage = {sh_q.stage[N-2:0], din_i};
        if (fall_i) sh_d.dout  = sh_q.stage[LAST];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign stages_o = sh_q.stage;
    assign dout_o   = sh_q.dout;
endmodule

// File: rtl/elseg_latch.sv
module elseg_latch #(
    parameter int unsigned N = elseg_pkg::SEG_CHANNELS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_n_i,
    input  logic [N-1:0] din_i,
    output logic [N-1:0] q_o
);
    typedef struct packed {
        logic [N-1:0] bits;
    } latch_t;

    latch_t lt_d, lt_q;

    always_comb begin
        lt_d = lt_q;
        if (!load_n_i) lt_d.bits = din_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lt_q <= '0;
        else        lt_q <= lt_d;
    end

    assign q_o = lt_q.bits;
endmodule

// File: rtl/elseg_drv.sv
module elseg_drv #(
    parameter int unsigned CHANNELS    = elseg_pkg::SEG_CHANNELS,
    parameter int unsigned SYNC_STAGES = elseg_pkg::SYNC_DEPTH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_i,
    input  logic                sdata_i,
    input  logic                load_n_i,
    input  logic                pol_n_i,
    output logic                sdata_o,
    output logic [CHANNELS-1:0] seg_o,
    output logic                bp_o
);
    import elseg_pkg::*;

    logic                sclk_rise;
    logic                sclk_fall;
    logic                data_sync;
    logic [CHANNELS-1:0] shift_q;
    logic [CHANNELS-1:0] lat_q;
    pol_mode_e           mode;

    elseg_strobe #(.SYNC(SYNC_STAGES)) u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_i  (sclk_i),
        .sdata_i (sdata_i),
        .rise_o  (sclk_rise),
        .fall_o  (sclk_fall),
        .data_o  (data_sync)
    );

    elseg_shift #(.N(CHANNELS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_i   (sclk_rise),
        .fall_i   (sclk_fall),
        .din_i    (data_sync),
        .stages_o (shift_q),
        .dout_o   (sdata_o)
    );

    elseg_latch #(.N(CHANNELS)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_n_i (load_n_i),
        .din_i    (shift_q),
        .q_o      (lat_q)
    );

    assign mode = pol_mode_e'(pol_n_i);
    assign bp_o = (mode == POL_INVERT);

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
        always_comb begin
            if (mode == POL_PASS) seg_o[ch] = lat_q[ch];
            else                  seg_o[ch] = ~lat_q[ch];
        end
    end
endmodule

// File: rtl/elseg_drv_chk.sv
module elseg_drv_chk #(
    parameter int unsigned N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         load_n_i,
    input logic         pol_n_i,
    input logic         sdata_o,
    input logic [N-1:0] seg_o,
    input logic         sclk_rise,
    input logic         sclk_fall,
    input logic [N-1:0] shift_q
);
    // R2: shift register moves only on a detected rising strobe
    p_shift_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sclk_rise)) |-> $stable(shift_q));

    // R3: cascade output moves only after a detected falling strobe
    p_dout_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sclk_fall)) |-> $stable(sdata_o));

    // R4: with load low, pass-mode outputs follow the shift register one cycle late
    p_latch_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load_n_i) && pol_n_i && $past(pol_n_i))
        |-> (seg_o == $past(shift_q)));

    // R5: with load high and polarity steady, outputs are frozen
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load_n_i) && $stable(pol_n_i)) |-> $stable(seg_o));

    // R7: a polarity change with the latch holding flips every output
    p_invert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load_n_i) && (pol_n_i != $past(pol_n_i)))
        |-> (seg_o == ~$past(seg_o)));
endmodule

bind elseg_drv elseg_drv_chk #(.N(CHANNELS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_n_i  (load_n_i),
    .pol_n_i   (pol_n_i),
    .sdata_o   (sdata_o),
    .seg_o     (seg_o),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .shift_q   (shift_q)
);

// File: tb/tb_elseg_drv.sv
module tb_elseg_drv;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic sdata = 1'b0;
    logic load_n = 1'b1;
    logic pol_n = 1'b1;
    logic        dout_a, dout_b, bp_a, bp_b;
    logic [15:0] seg_a, seg_b;

    always #10 clk = ~clk;   // 50 MHz

    elseg_drv dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sdata),
        .load_n_i(load_n), .pol_n_i(pol_n),
        .sdata_o(dout_a), .seg_o(seg_a), .bp_o(bp_a)
    );

    elseg_drv u_down (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(dout_a),
        .load_n_i(load_n), .pol_n_i(pol_n),
        .sdata_o(dout_b), .seg_o(seg_b), .bp_o(bp_b)
    );

    typedef struct {
        string       req;
        int          sel;
        logic [15:0] exp;
    } item_t;

    item_t sb_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state, built from the requirements
    logic [15:0] ref_a = '0, ref_b = '0, lat_a = '0, lat_b = '0;
    logic        ref_dout = 1'b0;
    bit          transparent = 0;
    localparam logic [31:0] PAT = 32'hC3A5_0F69;

    function automatic logic [15:0] pick(int sel);
        case (sel)
            0:       return seg_a;
            1:       return seg_b;
            2:       return {15'b0, bp_a};
            default: return {15'b0, dout_a};
        endcase
    endfunction

    // monitor: pops expected items and compares away from the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = sb_q.pop_front();
                act = pick(it.sel);
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic expect_val(input string req, input int sel, input logic [15:0] exp);
        item_t it;
        it.req = req; it.sel = sel; it.exp = exp;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic send_bit(input logic b);
        logic old;
        @(negedge clk);
        sdata = b;
        repeat (6) @(negedge clk);
        sclk = 1'b1;
        old  = ref_dout;
        ref_b = {ref_b[14:0], ref_dout};
        ref_a = {ref_a[14:0], b};
        if (transparent) begin lat_a = ref_a; lat_b = ref_b; end
        repeat (6) @(negedge clk);
        expect_val("R3 cascade output unchanged after rising edge", 3, {15'b0, old});
        @(negedge clk);
        sclk = 1'b0;
        ref_dout = ref_a[15];
        repeat (6) @(negedge clk);
        expect_val("R3 cascade output equals last stage after falling edge", 3, {15'b0, ref_dout});
    endtask

    task automatic pulse_load();
        @(negedge clk);
        load_n = 1'b0;
        repeat (4) @(negedge clk);
        load_n = 1'b1;
        lat_a = ref_a; lat_b = ref_b;
        repeat (2) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1 values checked while reset is held
        expect_val("R1 segments clear in reset", 0, 16'h0000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        expect_val("R1 upstream segments clear", 0, 16'h0000);
        expect_val("R1 downstream segments clear", 1, 16'h0000);
        expect_val("R1 backplane low", 2, 16'h0000);
        expect_val("R1 cascade output low", 3, 16'h0000);

        // R2 R8 R5: shift 32 bits through the chain with load high
        for (int i = 31; i >= 0; i--) begin
            send_bit(PAT[i]);
            if (i % 8 == 0) begin
                expect_val("R5 upstream outputs frozen while shifting", 0, 16'h0000);
                expect_val("R5 downstream outputs frozen while shifting", 1, 16'h0000);
            end
        end

        pulse_load();
        expect_val("R2 upstream segments show shift stages", 0, ref_a);
        expect_val("R2 stage order: bit0 holds last bit sent", 0,
                   {15'b0, PAT[0]} | (seg_a & 16'hFFFE));
        expect_val("R8 downstream holds first 16 bits", 1, ref_b);
        expect_val("R8 first bit in downstream stage 15", 1,
                   {PAT[31], 15'b0} | (seg_b & 16'h7FFF));
        expect_val("R6 backplane low in pass mode", 2, 16'h0000);

        // R4: transparent latch follows shifting
        @(negedge clk);
        load_n = 1'b0;
        transparent = 1;
        send_bit(1'b1);
        expect_val("R4 transparent latch follows upstream", 0, ref_a);
        expect_val("R4 transparent latch follows downstream", 1, ref_b);
        send_bit(1'b0);
        expect_val("R4 transparent latch follows second shift", 0, ref_a);
        @(negedge clk);
        load_n = 1'b1;
        transparent = 0;
        lat_a = ref_a; lat_b = ref_b;
        send_bit(1'b1);
        send_bit(1'b1);
        expect_val("R5 latch holds after load returns high", 0, lat_a);
        expect_val("R5 downstream latch holds", 1, lat_b);

        // R7: invert mode
        @(negedge clk);
        pol_n = 1'b0;
        repeat (2) @(negedge clk);
        expect_val("R7 upstream outputs inverted", 0, ~lat_a);
        expect_val("R7 downstream outputs inverted", 1, ~lat_b);
        expect_val("R7 backplane high in invert mode", 2, 16'h0001);

        // R9 / R6: back to pass mode restores outputs
        @(negedge clk);
        pol_n = 1'b1;
        repeat (2) @(negedge clk);
        expect_val("R9 upstream restored after polarity toggle", 0, lat_a);
        expect_val("R9 downstream restored after polarity toggle", 1, lat_b);
        expect_val("R6 backplane low after return to pass mode", 2, 16'h0000);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule